// File: doc/BRIEF.md
# EMS page window translator

This block lets a processor reach a large pool of expanded memory in DRAM through four 16 KB windows that sit in the upper memory area. Each window has a page register that software programs over I/O space. It holds an enable bit and a 7-bit page number. Configuration fields supply four things: the position of the 64 KB frame, the I/O base of the page registers, a 2-bit region extension per window that selects one 2 MB region of DRAM, and the total expanded memory size.

On every memory cycle the block compares the incoming address with the frame. When the address falls in an enabled window, the block raises a hit and outputs the DRAM address. That address is the window's region base, plus its page times 16 KB, plus the offset inside the window. Any other address passes through unchanged with no hit. A window whose page lies beyond the configured size counts as disabled. The DRAM controller and wait-state logic are outside this block and consume the hit and address.

Top module: `ems_window_xlate`

## Requirements
- R1: After a synchronous active-low reset every page register holds page 0 with its window disabled, so a read of any page register returns 0x00 and no memory address hits.
- R2: The page register of window i sits at I/O address IOB + 0x4000·i, with IOB = 0x208 + 0x10·B and B = cfg_map[3:0]. A write to IOB + 0x4000·i or IOB + 1 + 0x4000·i updates that register, and a write to any other address changes no register.
- R3: On a decoded write, data bit 7 becomes the window enable and data bits 6:0 become the page. A read strobe at IOB + 0x4000·i returns {enable, page} with io_rvalid high. A read at IOB + 1 + 0x4000·i gives io_rvalid low.
- R4: Window i covers the memory addresses from 0xC0000 + 0x4000·(F + i) up to 16 KB above that, with F = cfg_map[7:4]. An address below or above the four windows never hits.
- R5: For a hit in window i, phys_addr = (E_i << 21) + page_i·0x4000 + (mem_addr mod 0x4000). The extension E_i is taken from cfg_ext: window 0 uses bits 7:6, window 1 uses bits 5:4, window 2 uses bits 3:2 and window 3 uses bits 1:0.
- R6: The size code cfg_size of 0 gives 32 available pages, and a code n from 1 to 7 gives 64·n pages. A window whose page is greater than or equal to that count does not hit, and reads back with bit 7 at 0, for as long as the condition holds.
- R7: While cfg_ems_en is 0 no address hits, I/O writes change no register, and io_rvalid stays 0.
- R8: Without a hit, phys_addr equals mem_addr.
- R9: A change of cfg_map relocates the frame and the I/O base in the same cycle. The page registers keep their contents, and the old I/O addresses no longer decode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ems_en | input | 1 | Master enable for windows and page registers |
| cfg_map | input | 8 | Frame select [7:4], I/O base select [3:0] |
| cfg_ext | input | 8 | 2-bit region extension per window |
| cfg_size | input | 3 | Expanded memory size code |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Page register read data |
| io_rvalid | output | 1 | High when a read strobe decodes a page register |
| mem_addr | input | 24 | Memory access address |
| mem_hit | output | 1 | Address falls in an enabled, valid window |
| phys_addr | output | 24 | Translated DRAM address, or mem_addr on a miss |

## Verification
The bench goes after these corner cases:
- The first and last byte of each window. A wrong window compare would send these to the neighbouring page or miss them.
- The bytes just outside the frame, and an address that equals the frame only when its upper bits are dropped. A compare on too few bits would give a false hit here.
- The size limit at pages 31 and 32 for the 512 KB code, and the same pages once the size grows. An off-by-one limit would block page 31 or let page 32 through.
- A write to the old I/O base after relocation, and a write while the master enable is off. Either one would silently corrupt a page register if the decode were wrong.
- Reversed extension ordering. Reversed ordering would put window 0 in window 3's region.

// File: rtl/ems_pkg.sv
// Package: shared constants, page entry type and page-limit check for the
// expanded memory window translator. Assumes a 7-bit page and 16 KB pages.
package ems_pkg;
    localparam int PAGE_W        = 7;
    localparam int SIZE_W        = 3;
    localparam int SMALL_PAGES   = 32;   // size code 0: 512 KB
    localparam int PAGES_PER_MB  = 64;   // 1 MB / 16 KB
    localparam int LIM_W         = 10;

    typedef struct packed {
        logic              en;
        logic [PAGE_W-1:0] page;
    } page_entry_t;

    // True when the page lies inside the configured expanded memory size.
    function automatic logic page_in_range(logic [PAGE_W-1:0] pg,
                                           logic [SIZE_W-1:0] code);
        logic [LIM_W-1:0] lim;
        lim = (code == '0) ? LIM_W'(SMALL_PAGES)
                           : LIM_W'(code) * LIM_W'(PAGES_PER_MB);
        return LIM_W'(pg) < lim;
    endfunction
endpackage

// File: rtl/ems_page_regs.sv
// Module: page registers with their I/O decode. Holds one {enable, page}
// entry per window, written at IO_ORG + IO_STEP*B + WIN_IO_STRIDE*i (or +1)
// and read back at the even address. Assumes the window index is carried in
// the top bits of the I/O address. The enable that is seen outside is
// cleared while the page exceeds the configured size.
module ems_page_regs
    import ems_pkg::*;
#(
    parameter int NUM_WIN  = 4,
    parameter int IO_W     = 16,
    parameter int IO_ORG   = 'h208,
    parameter int IO_STEP  = 'h10,
    parameter int SEL_W    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ems_en,
    input  logic [SEL_W-1:0]          io_sel,
    input  logic [SIZE_W-1:0]         size_code,
    input  logic [IO_W-1:0]           io_addr,
    input  logic                      io_wr,
    input  logic                      io_rd,
    input  logic [7:0]                io_wdata,
    output logic [7:0]                io_rdata,
    output logic                      io_rvalid,
    output logic [NUM_WIN-1:0]        win_en,
    output logic [NUM_WIN*PAGE_W-1:0] win_page
);
    localparam int IDX_W = $clog2(NUM_WIN);
    localparam int LOW_W = IO_W - IDX_W;

    page_entry_t               regs_q [NUM_WIN];
    logic [LOW_W-1:0]          base_low;
    logic                      even_match;
    logic                      pair_match;
    logic [IDX_W-1:0]          idx;
    logic [NUM_WIN-1:0]        wr_sel;
    logic [NUM_WIN-1:0]        valid;

    // Decode the configured I/O base against the low address bits.
    always_comb begin
        base_low   = LOW_W'(IO_ORG) + LOW_W'(IO_STEP) * LOW_W'(io_sel);
        idx        = io_addr[IO_W-1 -: IDX_W];
        even_match = (io_addr[LOW_W-1:0] == base_low);
        pair_match = (io_addr[LOW_W-1:1] == base_low[LOW_W-1:1]);
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_WIN; gi++) begin : g_win
            assign wr_sel[gi] = ems_en && io_wr && pair_match && (idx == IDX_W'(gi));
            assign valid[gi]  = page_in_range(regs_q[gi].page, size_code);
            assign win_en[gi] = regs_q[gi].en && valid[gi];
            assign win_page[gi*PAGE_W +: PAGE_W] = regs_q[gi].page;

            // Load enable and page on a decoded write; clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs_q[gi] <= '0;
                end else if (wr_sel[gi]) begin
                    regs_q[gi].en   <= io_wdata[7];
                    regs_q[gi].page <= io_wdata[PAGE_W-1:0];
                end
            end

            // R3: a decoded write lands in the addressed register
            p_wr_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
                wr_sel[gi] |=> (regs_q[gi].page == $past(io_wdata[PAGE_W-1:0])));

            // R7: with the master enable off the register holds
            p_hold_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !ems_en |=> $stable(regs_q[gi]));

            // R1: coming out of reset the window is disabled
            p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) |-> !win_en[gi]);
        end
    endgenerate

    // Read port: even address of the selected window only.
    always_comb begin
        io_rvalid = ems_en && io_rd && even_match;
        io_rdata  = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (idx == IDX_W'(i)) io_rdata = {win_en[i], regs_q[i].page};
        end
    end

    // R2: at most one window register is written per cycle
    p_wr_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));
endmodule

// File: rtl/ems_xlate.sv
// Module: window hit detection and address translation. Compares the 16 KB
// block number of the access with the frame and forms
// {extension, page, offset} for a hit. Assumes FRAME_ORG is 16 KB aligned.
module ems_xlate
    import ems_pkg::*;
#(
    parameter int NUM_WIN   = 4,
    parameter int ADDR_W    = 24,
    parameter int WIN_SH    = 14,
    parameter int EXT_W     = 2,
    parameter int SEL_W     = 4,
    parameter int FRAME_ORG = 'hC0000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ems_en,
    input  logic [SEL_W-1:0]          frame_sel,
    input  logic [NUM_WIN*EXT_W-1:0]  ext_cfg,
    input  logic [NUM_WIN-1:0]        win_en,
    input  logic [NUM_WIN*PAGE_W-1:0] win_page,
    input  logic [ADDR_W-1:0]         mem_addr,
    output logic                      mem_hit,
    output logic [ADDR_W-1:0]         phys_addr
);
    localparam int BLK_W = ADDR_W - WIN_SH;
    localparam int PAD_W = ADDR_W - EXT_W - PAGE_W - WIN_SH;
    localparam logic [BLK_W-1:0] ORG_BLK = BLK_W'(FRAME_ORG >> WIN_SH);

    logic [BLK_W-1:0]   blk;
    logic [BLK_W-1:0]   frame_blk;
    logic [NUM_WIN-1:0] win_hit;

    assign blk       = mem_addr[ADDR_W-1:WIN_SH];
    assign frame_blk = ORG_BLK + BLK_W'(frame_sel);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_WIN; gi++) begin : g_hit
            assign win_hit[gi] = ems_en && win_en[gi] && (blk == frame_blk + BLK_W'(gi));
        end
    endgenerate

    // Select the hitting window and build the DRAM address.
    always_comb begin
        mem_hit   = |win_hit;
        phys_addr = mem_addr;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (win_hit[i]) begin
                phys_addr = {{PAD_W{1'b0}},
                             ext_cfg[(NUM_WIN-1-i)*EXT_W +: EXT_W],
                             win_page[i*PAGE_W +: PAGE_W],
                             mem_addr[WIN_SH-1:0]};
            end
        end
    end

    // R4: one window at most claims an access
    p_one_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_hit));

    // R5: the in-window offset is carried unchanged
    p_offset_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hit |-> (phys_addr[WIN_SH-1:0] == mem_addr[WIN_SH-1:0]));

    // R7: no hit without the master enable
    p_hit_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hit |-> ems_en);
endmodule

// File: rtl/ems_window_xlate.sv
// Module: top of the expanded memory window translator. Splits the mapping
// configuration into frame and I/O base selects and joins the page
// registers to the translator. Memory translation is combinational; page
// registers update on the clock edge after a write.
module ems_window_xlate
    import ems_pkg::*;
#(
    parameter int NUM_WIN   = 4,
    parameter int ADDR_W    = 24,
    parameter int IO_W      = 16,
    parameter int WIN_SH    = 14,
    parameter int EXT_W     = 2,
    parameter int SEL_W     = 4,
    parameter int FRAME_ORG = 'hC0000,
    parameter int IO_ORG    = 'h208,
    parameter int IO_STEP   = 'h10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_ems_en,
    input  logic [2*SEL_W-1:0]       cfg_map,
    input  logic [NUM_WIN*EXT_W-1:0] cfg_ext,
    input  logic [SIZE_W-1:0]        cfg_size,
    input  logic [IO_W-1:0]          io_addr,
    input  logic                     io_wr,
    input  logic                     io_rd,
    input  logic [7:0]               io_wdata,
    output logic [7:0]               io_rdata,
    output logic                     io_rvalid,
    input  logic [ADDR_W-1:0]        mem_addr,
    output logic                     mem_hit,
    output logic [ADDR_W-1:0]        phys_addr
);
    logic [NUM_WIN-1:0]        win_en;
    logic [NUM_WIN*PAGE_W-1:0] win_page;

    ems_page_regs #(
        .NUM_WIN(NUM_WIN), .IO_W(IO_W), .IO_ORG(IO_ORG),
        .IO_STEP(IO_STEP), .SEL_W(SEL_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .ems_en(cfg_ems_en),
        .io_sel(cfg_map[SEL_W-1:0]), .size_code(cfg_size),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_rvalid(io_rvalid),
        .win_en(win_en), .win_page(win_page)
    );

    ems_xlate #(
        .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .WIN_SH(WIN_SH),
        .EXT_W(EXT_W), .SEL_W(SEL_W), .FRAME_ORG(FRAME_ORG)
    ) u_xlate (
        .clk(clk), .rst_n(rst_n), .ems_en(cfg_ems_en),
        .frame_sel(cfg_map[2*SEL_W-1:SEL_W]), .ext_cfg(cfg_ext),
        .win_en(win_en), .win_page(win_page),
        .mem_addr(mem_addr), .mem_hit(mem_hit), .phys_addr(phys_addr)
    );

    // R8: a miss leaves the address untouched
    p_pass_through_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_hit |-> (phys_addr == mem_addr));
endmodule

// File: tb/tb_ems_window_xlate.sv
module tb_ems_window_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ems_en = 1'b1;
    logic [7:0]  cfg_map = 8'h00;
    logic [7:0]  cfg_ext = 8'h00;
    logic [2:0]  cfg_size = 3'd2;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_rvalid;
    logic [23:0] mem_addr = '0;
    logic        mem_hit;
    logic [23:0] phys_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    ems_window_xlate dut (
        .clk(clk), .rst_n(rst_n), .cfg_ems_en(cfg_ems_en), .cfg_map(cfg_map),
        .cfg_ext(cfg_ext), .cfg_size(cfg_size), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_rvalid(io_rvalid), .mem_addr(mem_addr),
        .mem_hit(mem_hit), .phys_addr(phys_addr)
    );

    // {addr, hit, phys}; setup: F=0, ext=0xE4, w0=en/5, w1=en/127, w2=off, w3=en/1
    localparam logic [48:0] VEC [10] = '{
        {24'h0C0000, 1'b1, 24'h614000},
        {24'h0C3FFF, 1'b1, 24'h617FFF},
        {24'h0C4000, 1'b1, 24'h5FC000},
        {24'h0C7ABC, 1'b1, 24'h5FFABC},
        {24'h0C8010, 1'b0, 24'h0C8010},
        {24'h0CC123, 1'b1, 24'h004123},
        {24'h0CFFFF, 1'b1, 24'h007FFF},
        {24'h0BFFFF, 1'b0, 24'h0BFFFF},
        {24'h0D0000, 1'b0, 24'h0D0000},
        {24'h1C0000, 1'b0, 24'h1C0000}
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic io_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(logic [15:0] a, output logic v, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #2;
        v = io_rvalid; d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic mem_check(string tag, logic [23:0] a, logic h, logic [23:0] p);
        @(negedge clk);
        mem_addr = a;
        #2;
        check({tag, " hit"}, 32'(mem_hit), 32'(h));
        check({tag, " phys"}, 32'(phys_addr), 32'(p));
    endtask

    task automatic rd_check(string tag, logic [15:0] a, logic ev, logic [7:0] ed);
        logic v;
        logic [7:0] d;
        io_read(a, v, d);
        check({tag, " rvalid"}, 32'(v), 32'(ev));
        if (ev) check({tag, " rdata"}, 32'(d), 32'(ed));
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd_check("R1 w0 reset", 16'h0208, 1'b1, 8'h00);
        rd_check("R1 w3 reset", 16'hC208, 1'b1, 8'h00);
        mem_check("R1 no hit", 24'h0C0000, 1'b0, 24'h0C0000);

        // R2/R3: program the four windows, using both odd and even addresses
        cfg_ext = 8'hE4;
        io_write(16'h0208, 8'h85);
        io_write(16'h4209, 8'hFF);
        io_write(16'h8208, 8'h00);
        io_write(16'hC208, 8'h81);
        io_write(16'h020A, 8'h9F); // not decoded, R2
        rd_check("R3 w0", 16'h0208, 1'b1, 8'h85);
        rd_check("R2 w1 via odd write", 16'h4208, 1'b1, 8'hFF);
        rd_check("R3 w2 disabled", 16'h8208, 1'b1, 8'h00);
        rd_check("R3 odd read", 16'h0209, 1'b0, 8'h00);

        // R4 R5 R8: vector table
        for (int i = 0; i < 10; i++) begin
            mem_check($sformatf("R5 vec%0d", i), VEC[i][48:25], VEC[i][24], VEC[i][23:0]);
        end

        // R6: size limit
        cfg_size = 3'd0;
        mem_check("R6 page127 over 32", 24'h0C4000, 1'b0, 24'h0C4000);
        rd_check("R6 readback forced off", 16'h4208, 1'b1, 8'h7F);
        io_write(16'hC208, 8'h9F);
        mem_check("R6 page31 ok", 24'h0CC000, 1'b1, 24'h07C000);
        io_write(16'hC208, 8'hA0);
        mem_check("R6 page32 blocked", 24'h0CC000, 1'b0, 24'h0CC000);
        cfg_size = 3'd1;
        mem_check("R6 page32 with 1MB", 24'h0CC000, 1'b1, 24'h080000);

        // R9: relocation F=2, B=1
        cfg_map = 8'h21;
        mem_check("R9 new frame", 24'h0C8000, 1'b1, 24'h614000);
        mem_check("R9 old frame", 24'h0C0000, 1'b0, 24'h0C0000);
        rd_check("R9 new io base", 16'h0218, 1'b1, 8'h85);
        rd_check("R9 old io base", 16'h0208, 1'b0, 8'h00);
        io_write(16'h0208, 8'h80);
        rd_check("R9 old base write ignored", 16'h0218, 1'b1, 8'h85);

        // R7: master enable off
        cfg_ems_en = 1'b0;
        mem_check("R7 no hit", 24'h0C8000, 1'b0, 24'h0C8000);
        rd_check("R7 no rvalid", 16'h0218, 1'b0, 8'h00);
        io_write(16'h0218, 8'h00);
        cfg_ems_en = 1'b1;
        rd_check("R7 write ignored", 16'h0218, 1'b1, 8'h85);

        // R1: reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_check("R1 mid reset", 16'h0218, 1'b1, 8'h00);
        mem_check("R1 mid reset miss", 24'h0C8000, 1'b0, 24'h0C8000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule